// File: doc/BRIEF.md
# Local Window to PCI Request Translator

This block sits between a local bus and a PCI master engine. Local accesses whose two top address bits select a fixed 1 GiB window become PCI request descriptors. Each descriptor carries a four-bit bus command, a 32-bit PCI address, active-low byte enables and write data. A single control register chooses how the window is used. In memory mode an access becomes a memory read or write, and the register supplies the two upper PCI address bits. In configuration mode the window offset is read as a device, function and register triple. The device number is expanded into a one-hot IDSEL line on the address.

The same control register drives the PCI reset pin through a two-bit mode field. It also stores a grant policy and a cache-off flag, which are passed on to neighbouring logic. A request is presented with a strobe and held until the engine accepts it. The read data, or an abort indication, then goes back to the local side. Illegal accesses are refused at once and no bus cycle is started.

Top module: `pci_window_xlat`

## Requirements
- R1: An access is forwarded only when lb_addr[31:30] is 2'b10. Any other access is ignored: no pci_req, no lb_done, and lb_busy stays low.
- R2: In memory mode (control bit 1 = 0), pci_addr is {control[3:2], lb_addr[29:0]}. pci_cmd is 4'h6 for a read and 4'h7 for a write.
- R3: In configuration mode (control bit 1 = 1), the offset fields are device = lb_addr[15:11], function = lb_addr[10:8] and register = lb_addr[7:2]. pci_addr is (1 << (13 + device)) | function << 8 | register << 2, with bits 1:0 zero. pci_cmd is 4'hA for a read and 4'hB for a write.
- R4: In configuration mode an access is refused when any of these holds: the device is above 18, 13 + device reaches 20 (so the IDSEL bit would fall at or above offset 0x100000), or any of lb_addr[29:16] is set. A refused access raises lb_done and lb_err with lb_rdata = 32'hFFFFFFFF on the next cycle, and no pci_req is made.
- R5: lb_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = illegal. pci_be_n has a 0 for each byte lane from lb_addr[1:0] up to lb_addr[1:0] + size - 1. An access that is misaligned for its size, or uses size 3, is refused as in R4.
- R6: pci_req rises in the cycle after an accepted request. pci_cmd, pci_addr, pci_be_n and pci_wdata stay constant until pci_accept is sampled high, and pci_req is low in the following cycle.
- R7: One cycle after the accept, lb_done pulses. If pci_abort was low, lb_abort = 0 and lb_rdata = pci_rdata. If pci_abort was high, lb_abort = 1 and lb_rdata = 32'hFFFFFFFF.
- R8: lb_busy is high from the cycle after acceptance until completion. Requests made while busy are ignored. The mode in force at acceptance governs the whole access.
- R9: The control register resets to 0. A write keeps bits 1, 3:2, 5:4, 7:6 and 12, and all other bits read back as 0. A read returns the value on reg_rdata in the next cycle. When a read and a write share a cycle, the read returns the old value.
- R10: Reset-pin mode control[5:4] sets the pin in the cycle after the write. Mode 0 gives prst_oe = 0, mode 1 gives prst_oe = 1 and prst_out = 0, mode 2 gives prst_oe = 1 and prst_out = 1, and mode 3 gives prst_oe = 0.
- R11: grant_mode presents control[7:6] and cache_off presents control[12], both from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data, one cycle after reg_rd |
| lb_req | input | 1 | Local access request, one cycle |
| lb_we | input | 1 | Local access is a write |
| lb_addr | input | 32 | Local address |
| lb_size | input | 2 | Access size code |
| lb_wdata | input | 32 | Local write data, lane aligned |
| lb_busy | output | 1 | An access is outstanding |
| lb_done | output | 1 | Completion pulse |
| lb_err | output | 1 | Access refused |
| lb_abort | output | 1 | PCI cycle aborted |
| lb_rdata | output | 32 | Returned read data |
| pci_req | output | 1 | Request strobe towards the PCI engine |
| pci_cmd | output | 4 | PCI bus command |
| pci_addr | output | 32 | PCI address |
| pci_be_n | output | 4 | Active-low byte enables |
| pci_wdata | output | 32 | Write data |
| pci_accept | input | 1 | Engine has finished the request |
| pci_abort | input | 1 | The finished request was aborted |
| pci_rdata | input | 32 | Read data with pci_accept |
| prst_oe | output | 1 | PCI reset pin output enable |
| prst_out | output | 1 | PCI reset pin level when driven |
| grant_mode | output | 2 | Stored grant policy |
| cache_off | output | 1 | Stored cache-disable flag |

## Verification
The assertions assume that pci_accept is a one-cycle pulse that comes only while pci_req is high, and that pci_abort and pci_rdata are valid in that same cycle. They also assume that every input is changed away from the clock edge. The bench's PCI responder watches pci_req, waits a programmable number of cycles and then pulses the accept exactly once. All stimulus is applied on the falling edge, so the responder never accepts a request that is not pending.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

  // PCI bus command codes
  typedef enum logic [3:0] {
    CMD_MEM_RD = 4'h6,
    CMD_MEM_WR = 4'h7,
    CMD_CFG_RD = 4'hA,
    CMD_CFG_WR = 4'hB
  } pci_cmd_e;

  // Top address bits that select the translated window
  localparam logic [1:0] WIN_TAG = 2'b10;

  typedef struct packed {
    logic       cache_dis;
    logic [1:0] grant;
    logic [1:0] rst_mode;
    logic [1:0] top_bits;
    logic       cfg_sel;
  } ctrl_t;

endpackage

// File: rtl/pwx_ctrl_reg.sv
module pwx_ctrl_reg
  import pwx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic              pin_oe,
  output logic              pin_out
);
  localparam int POS_CFG  = 1;
  localparam int POS_TOP  = 2;
  localparam int POS_RST  = 4;
  localparam int POS_GNT  = 6;
  localparam int POS_CDIS = 12;

  function automatic logic [DATA_W-1:0] pack(input ctrl_t c);
    logic [DATA_W-1:0] v;
    v = '0;
    v[POS_CFG]        = c.cfg_sel;
    v[POS_TOP +: 2]   = c.top_bits;
    v[POS_RST +: 2]   = c.rst_mode;
    v[POS_GNT +: 2]   = c.grant;
    v[POS_CDIS]       = c.cache_dis;
    return v;
  endfunction

  ctrl_t nxt;
  logic  unused_wbits;
  assign unused_wbits = ^wdata;

  always_comb begin
    nxt = ctrl;
    if (wr_en) begin
      nxt.cfg_sel   = wdata[POS_CFG];
      nxt.top_bits  = wdata[POS_TOP +: 2];
      nxt.rst_mode  = wdata[POS_RST +: 2];
      nxt.grant     = wdata[POS_GNT +: 2];
      nxt.cache_dis = wdata[POS_CDIS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      rdata   <= '0;
      pin_oe  <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      ctrl    <= nxt;
      if (rd_en) rdata <= pack(ctrl);
      pin_oe  <= (nxt.rst_mode == 2'd1) || (nxt.rst_mode == 2'd2);
      pin_out <= (nxt.rst_mode == 2'd2);
    end
  end

endmodule

// File: rtl/pwx_decode.sv
module pwx_decode
  import pwx_pkg::*;
#(
  parameter int BE_W          = 4,
  parameter int IDSEL_BASE    = 13,
  parameter int MAX_DEV       = 18,
  parameter int CFG_SPAN_LOG2 = 20
) (
  input  logic [31:0]     addr,
  input  logic            we,
  input  logic [1:0]      size,
  input  logic            cfg_sel,
  input  logic [1:0]      top_bits,
  output logic            hit,
  output logic            reject,
  output logic [3:0]      cmd,
  output logic [31:0]     pci_addr,
  output logic [BE_W-1:0] be_n
);
  localparam int LANE_W    = $clog2(BE_W);
  localparam int FIT_DEV   = CFG_SPAN_LOG2 - IDSEL_BASE - 1;
  localparam int DEV_LIMIT = (MAX_DEV < FIT_DEV) ? MAX_DEV : FIT_DEV;
  localparam int DEV_LSB   = 11;
  localparam int DEV_W     = 5;
  localparam int FIELD_TOP = DEV_LSB + DEV_W;

  logic [DEV_W-1:0]  dev;
  logic [LANE_W-1:0] low;
  logic              dev_ok, align_ok;
  logic [31:0]       cfg_addr, mem_addr;
  int                nbytes;
  pci_cmd_e          c;

  assign dev    = addr[DEV_LSB +: DEV_W];
  assign low    = addr[LANE_W-1:0];
  assign nbytes = 1 << size;

  generate
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign be_n[g] = !((g >= int'(low)) && (g < int'(low) + nbytes));
    end
  endgenerate

  always_comb begin
    dev_ok   = (int'(dev) <= DEV_LIMIT) && (addr[29:FIELD_TOP] == '0);
    align_ok = (nbytes <= BE_W) && ((int'(low) & (nbytes - 1)) == 0);
    cfg_addr = (32'd1 << (IDSEL_BASE + int'(dev))) | {21'd0, addr[10:2], 2'b00};
    mem_addr = {top_bits, addr[29:0]};
    if (cfg_sel) c = we ? CMD_CFG_WR : CMD_CFG_RD;
    else         c = we ? CMD_MEM_WR : CMD_MEM_RD;
    cmd      = c;
    pci_addr = cfg_sel ? cfg_addr : mem_addr;
    hit      = (addr[31:30] == WIN_TAG);
    reject   = !align_ok || (cfg_sel && !dev_ok);
  end

endmodule

// File: rtl/pwx_xact.sv
module pwx_xact #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              reject,
  input  logic [3:0]        cmd,
  input  logic [31:0]       addr,
  input  logic [BE_W-1:0]   be_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pci_accept,
  input  logic              pci_abort,
  input  logic [DATA_W-1:0] pci_rdata,
  output logic              pci_req,
  output logic [3:0]        pci_cmd,
  output logic [31:0]       pci_addr,
  output logic [BE_W-1:0]   pci_be_n,
  output logic [DATA_W-1:0] pci_wdata,
  output logic              lb_busy,
  output logic              lb_done,
  output logic              lb_err,
  output logic              lb_abort,
  output logic [DATA_W-1:0] lb_rdata
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st;

  assign lb_busy = (st == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pci_req   <= 1'b0;
      pci_cmd   <= '0;
      pci_addr  <= '0;
      pci_be_n  <= '1;
      pci_wdata <= '0;
      lb_done   <= 1'b0;
      lb_err    <= 1'b0;
      lb_abort  <= 1'b0;
      lb_rdata  <= '0;
    end else begin
      lb_done  <= 1'b0;
      lb_err   <= 1'b0;
      lb_abort <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (reject) begin
            lb_done  <= 1'b1;
            lb_err   <= 1'b1;
            lb_rdata <= '1;
          end else begin
            st        <= ST_WAIT;
            pci_req   <= 1'b1;
            pci_cmd   <= cmd;
            pci_addr  <= addr;
            pci_be_n  <= be_n;
            pci_wdata <= wdata;
          end
        end
        ST_WAIT: if (pci_accept) begin
          st       <= ST_IDLE;
          pci_req  <= 1'b0;
          lb_done  <= 1'b1;
          lb_abort <= pci_abort;
          lb_rdata <= pci_abort ? '1 : pci_rdata;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_window_xlat.sv
module pci_window_xlat
  import pwx_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int IDSEL_BASE    = 13,
  parameter int MAX_DEV       = 18,
  parameter int CFG_SPAN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              lb_req,
  input  logic              lb_we,
  input  logic [31:0]       lb_addr,
  input  logic [1:0]        lb_size,
  input  logic [DATA_W-1:0] lb_wdata,
  output logic              lb_busy,
  output logic              lb_done,
  output logic              lb_err,
  output logic              lb_abort,
  output logic [DATA_W-1:0] lb_rdata,
  output logic              pci_req,
  output logic [3:0]        pci_cmd,
  output logic [31:0]       pci_addr,
  output logic [DATA_W/8-1:0] pci_be_n,
  output logic [DATA_W-1:0] pci_wdata,
  input  logic              pci_accept,
  input  logic              pci_abort,
  input  logic [DATA_W-1:0] pci_rdata,
  output logic              prst_oe,
  output logic              prst_out,
  output logic [1:0]        grant_mode,
  output logic              cache_off
);
  localparam int BE_W = DATA_W / 8;

  ctrl_t           ctrl;
  logic            hit, reject;
  logic [3:0]      d_cmd;
  logic [31:0]     d_addr;
  logic [BE_W-1:0] d_be_n;

  pwx_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl(ctrl), .pin_oe(prst_oe), .pin_out(prst_out)
  );

  pwx_decode #(
    .BE_W(BE_W), .IDSEL_BASE(IDSEL_BASE), .MAX_DEV(MAX_DEV),
    .CFG_SPAN_LOG2(CFG_SPAN_LOG2)
  ) u_dec (
    .addr(lb_addr), .we(lb_we), .size(lb_size), .cfg_sel(ctrl.cfg_sel),
    .top_bits(ctrl.top_bits), .hit(hit), .reject(reject), .cmd(d_cmd),
    .pci_addr(d_addr), .be_n(d_be_n)
  );

  pwx_xact #(.DATA_W(DATA_W), .BE_W(BE_W)) u_xact (
    .clk(clk), .rst(rst), .start(lb_req && hit), .reject(reject),
    .cmd(d_cmd), .addr(d_addr), .be_n(d_be_n), .wdata(lb_wdata),
    .pci_accept(pci_accept), .pci_abort(pci_abort), .pci_rdata(pci_rdata),
    .pci_req(pci_req), .pci_cmd(pci_cmd), .pci_addr(pci_addr),
    .pci_be_n(pci_be_n), .pci_wdata(pci_wdata), .lb_busy(lb_busy),
    .lb_done(lb_done), .lb_err(lb_err), .lb_abort(lb_abort),
    .lb_rdata(lb_rdata)
  );

  assign grant_mode = ctrl.grant;
  assign cache_off  = ctrl.cache_dis;

endmodule

// File: rtl/pwx_checker.sv
module pwx_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lb_req,
  input logic [31:0]       lb_addr,
  input logic              lb_busy,
  input logic              lb_done,
  input logic              lb_err,
  input logic              lb_abort,
  input logic [DATA_W-1:0] lb_rdata,
  input logic              pci_req,
  input logic              pci_accept,
  input logic [3:0]        pci_cmd,
  input logic [31:0]       pci_addr,
  input logic [DATA_W/8-1:0] pci_be_n,
  input logic [DATA_W-1:0] pci_wdata,
  input logic              prst_oe,
  input logic              prst_out
);

  assert_outside_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    lb_req && !lb_busy && (lb_addr[31:30] != 2'b10) |=> !lb_done && !pci_req);

  assert_cfg_idsel_R3: assert property (@(posedge clk) disable iff (rst)
    pci_req && pci_cmd[3] |-> (pci_addr[1:0] == 2'b00) && ($countones(pci_addr[31:13]) == 1));

  assert_refuse_no_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    lb_err |-> lb_done && !pci_req);

  assert_lane_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    pci_req |-> (pci_be_n != '1));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    pci_req && !pci_accept |=> pci_req && $stable(pci_cmd) && $stable(pci_addr)
                               && $stable(pci_be_n) && $stable(pci_wdata));

  assert_done_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    pci_req && pci_accept |=> lb_done && !pci_req);

  assert_abort_data_R7: assert property (@(posedge clk) disable iff (rst)
    lb_abort |-> lb_done && (lb_rdata == '1));

  assert_req_busy_R8: assert property (@(posedge clk) disable iff (rst)
    pci_req |-> lb_busy);

  assert_pin_drive_R10: assert property (@(posedge clk) disable iff (rst)
    prst_out |-> prst_oe);

endmodule

bind pci_window_xlat pwx_checker #(.DATA_W(DATA_W)) u_pwx_checker (
  .clk(clk), .rst(rst), .lb_req(lb_req), .lb_addr(lb_addr), .lb_busy(lb_busy),
  .lb_done(lb_done), .lb_err(lb_err), .lb_abort(lb_abort), .lb_rdata(lb_rdata),
  .pci_req(pci_req), .pci_accept(pci_accept), .pci_cmd(pci_cmd),
  .pci_addr(pci_addr), .pci_be_n(pci_be_n), .pci_wdata(pci_wdata),
  .prst_oe(prst_oe), .prst_out(prst_out)
);

// File: tb/tb_pci_window_xlat.sv
module tb_pci_window_xlat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        lb_req = 1'b0, lb_we = 1'b0;
  logic [31:0] lb_addr = '0, lb_wdata = '0, lb_rdata;
  logic [1:0]  lb_size = 2'd2;
  logic        lb_busy, lb_done, lb_err, lb_abort;
  logic        pci_req, pci_accept = 1'b0, pci_abort = 1'b0;
  logic [3:0]  pci_cmd, pci_be_n;
  logic [31:0] pci_addr, pci_wdata, pci_rdata = '0;
  logic        prst_oe, prst_out, cache_off;
  logic [1:0]  grant_mode;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pci_window_xlat dut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_cfg, m_top, m_rmode, m_grant, m_cdis;
  logic        m_busy, m_req, m_done, m_err, m_abort, m_oe, m_out;
  logic [3:0]  m_cmd, m_ben;
  logic [31:0] m_addr, m_wdata, m_rdata, m_rreg;

  function automatic void ref_decode(input logic we, input logic [31:0] a,
      input logic [1:0] sz, input int cfg, input int top, output logic bad,
      output logic [3:0] cmd, output logic [31:0] pa, output logic [3:0] ben);
    int off, dev, n, low;
    off = int'(a & 32'h3FFF_FFFF);
    n   = 1 << sz;
    low = int'(a[1:0]);
    bad = (n > 4) || (low % n != 0);
    ben = 4'(~(((1 << n) - 1) << low));
    if (cfg != 0) begin
      dev = (off >> 11) & 31;
      if (dev > 18 || 13 + dev >= 20 || off >= 'h10000) bad = 1'b1;
      pa  = (dev <= 18) ? (32'(1 << (13 + dev)) | 32'(off & 'h7FC)) : 32'h0;
      cmd = we ? 4'hB : 4'hA;
    end else begin
      pa  = 32'(top) * 32'h4000_0000 + 32'(off);
      cmd = we ? 4'h7 : 4'h6;
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_top = 0; m_rmode = 0; m_grant = 0; m_cdis = 0;
      m_busy = 0; m_req = 0; m_done = 0; m_err = 0; m_abort = 0;
      m_oe = 0; m_out = 0; m_rdata = 0; m_rreg = 0;
    end else begin
      logic bad; logic [3:0] c, b; logic [31:0] pa;
      m_done = 0; m_err = 0; m_abort = 0;
      if (!m_busy && lb_req && lb_addr[31:30] == 2'b10) begin
        ref_decode(lb_we, lb_addr, lb_size, m_cfg, m_top, bad, c, pa, b);
        if (bad) begin
          m_done = 1; m_err = 1; m_rdata = 32'hFFFF_FFFF;
        end else begin
          m_busy = 1; m_req = 1; m_cmd = c; m_addr = pa; m_ben = b; m_wdata = lb_wdata;
        end
      end else if (m_busy && pci_accept) begin
        m_busy = 0; m_req = 0; m_done = 1; m_abort = pci_abort;
        m_rdata = pci_abort ? 32'hFFFF_FFFF : pci_rdata;
      end
      if (reg_rd)
        m_rreg = 32'(m_cdis * 4096 + m_grant * 64 + m_rmode * 16 + m_top * 4 + m_cfg * 2);
      if (reg_wr) begin
        m_cfg = int'(reg_wdata[1]); m_top = int'(reg_wdata[3:2]);
        m_rmode = int'(reg_wdata[5:4]); m_grant = int'(reg_wdata[7:6]);
        m_cdis = int'(reg_wdata[12]);
      end
      m_oe  = (m_rmode == 1 || m_rmode == 2);
      m_out = (m_rmode == 2);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R6", "pci_req", 32'(pci_req), 32'(m_req));
      chk("R8", "lb_busy", 32'(lb_busy), 32'(m_busy));
      chk("R1 R7", "lb_done", 32'(lb_done), 32'(m_done));
      chk("R4 R5", "lb_err", 32'(lb_err), 32'(m_err));
      chk("R7", "lb_abort", 32'(lb_abort), 32'(m_abort));
      if (m_done) chk("R7", "lb_rdata", lb_rdata, m_rdata);
      if (m_req) begin
        chk("R2 R3", "pci_cmd", 32'(pci_cmd), 32'(m_cmd));
        chk("R2 R3", "pci_addr", pci_addr, m_addr);
        chk("R5", "pci_be_n", 32'(pci_be_n), 32'(m_ben));
        chk("R6", "pci_wdata", pci_wdata, m_wdata);
      end
      chk("R9", "reg_rdata", reg_rdata, m_rreg);
      chk("R10", "prst", {30'd0, prst_oe, prst_out}, {30'd0, m_oe, m_out});
      chk("R11", "grant/cache", {29'd0, cache_off, grant_mode},
          32'(m_cdis * 4 + m_grant));
    end
  end

  // ---------------- PCI responder ----------------
  int          resp_delay = 0;
  logic        resp_abort = 1'b0;
  logic [31:0] resp_data = 32'h1234_5678;

  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (pci_accept) pci_accept = 1'b0;
      else if (pci_req) begin
        if (wcnt >= resp_delay) begin
          pci_accept = 1'b1; pci_rdata = resp_data; pci_abort = resp_abort; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic        cap_req, got_done, got_err, got_abort;
  logic [3:0]  cap_cmd, cap_be;
  logic [31:0] cap_addr, got_rdata;

  task automatic reg_write(logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic access(logic we, logic [31:0] a, logic [1:0] sz, logic [31:0] wd);
    @(negedge clk); lb_req = 1'b1; lb_we = we; lb_addr = a; lb_size = sz; lb_wdata = wd;
    @(negedge clk); lb_req = 1'b0;
    cap_req = pci_req; cap_cmd = pci_cmd; cap_addr = pci_addr; cap_be = pci_be_n;
    got_done = 0; got_err = 0; got_abort = 0; got_rdata = '0;
    for (int i = 0; i < 40; i++) begin
      if (lb_done) begin
        got_done = 1; got_err = lb_err; got_abort = lb_abort; got_rdata = lb_rdata;
        break;
      end
      if (!lb_busy && i >= 3) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9", "reset reg_rdata", reg_rdata, 32'h0);
    chk("R10", "reset prst_oe", 32'(prst_oe), 32'h0);

    reg_read(v);
    chk("R9", "reset value", v, 32'h0);
    reg_write(32'hFFFF_FFFF);
    reg_read(v);
    chk("R9", "kept bits", v, 32'h0000_10FE);
    chk("R11", "grant_mode", 32'(grant_mode), 32'h3);
    chk("R11", "cache_off", 32'(cache_off), 32'h1);
    chk("R10", "mode 3 undriven", 32'(prst_oe), 32'h0);
    reg_write(32'h0000_0010);
    chk("R10", "mode 1", {30'd0, prst_oe, prst_out}, 32'h2);
    reg_write(32'h0000_0028);  // reset pin high, top bits 2
    chk("R10", "mode 2", {30'd0, prst_oe, prst_out}, 32'h3);

    // memory mode
    resp_data = 32'hCAFE_F00D;
    access(1'b0, 32'h8000_1234, 2'd2, 32'h0);
    chk("R2", "mem rd addr", cap_addr, 32'h8000_1234);
    chk("R2", "mem rd cmd", 32'(cap_cmd), 32'h6);
    chk("R7", "mem rd data", got_rdata, 32'hCAFE_F00D);
    access(1'b1, 32'h9000_0003, 2'd0, 32'hAB00_0000);
    chk("R5", "byte lane 3", 32'(cap_be), 32'h7);
    chk("R2", "mem wr cmd", 32'(cap_cmd), 32'h7);
    access(1'b1, 32'h9000_0002, 2'd1, 32'h0);
    chk("R5", "half upper", 32'(cap_be), 32'h3);
    access(1'b0, 32'h9000_0001, 2'd1, 32'h0);
    chk("R5", "half misaligned refused", {30'd0, got_err, cap_req}, 32'h2);
    access(1'b0, 32'h9000_0000, 2'd3, 32'h0);
    chk("R5", "size 3 refused", 32'(got_err), 32'h1);
    access(1'b0, 32'h4000_0000, 2'd2, 32'h0);
    chk("R1", "low address ignored", {30'd0, got_done, cap_req}, 32'h0);
    access(1'b1, 32'hC000_0100, 2'd2, 32'h0);
    chk("R1", "high address ignored", {30'd0, got_done, cap_req}, 32'h0);

    // abort
    resp_abort = 1'b1;
    access(1'b0, 32'hA000_0010, 2'd2, 32'h0);
    chk("R7", "abort flag", 32'(got_abort), 32'h1);
    chk("R7", "abort data", got_rdata, 32'hFFFF_FFFF);
    resp_abort = 1'b0;

    // request while busy
    resp_delay = 8;
    @(negedge clk); lb_req = 1'b1; lb_we = 1'b0; lb_addr = 32'h8000_0040; lb_size = 2'd2;
    @(negedge clk); lb_addr = 32'h8000_0080;
    @(negedge clk); lb_req = 1'b0;
    begin
      int dones = 0;
      for (int i = 0; i < 15; i++) begin
        if (pci_req) chk("R8", "busy keeps first address", pci_addr, 32'h8000_0040);
        if (lb_done) dones++;
        @(negedge clk);
      end
      chk("R8", "one completion", 32'(dones), 32'h1);
    end
    resp_delay = 0;

    // configuration mode
    reg_write(32'h0000_0022);
    access(1'b0, 32'h8000_2A0C, 2'd2, 32'h0);
    chk("R3", "cfg addr dev5", cap_addr, 32'h0004_020C);
    chk("R3", "cfg rd cmd", 32'(cap_cmd), 32'hA);
    access(1'b1, 32'h8000_0005, 2'd0, 32'h0000_5500);
    chk("R3", "cfg addr dev0 low bits", cap_addr, 32'h0000_2004);
    chk("R3", "cfg wr cmd", 32'(cap_cmd), 32'hB);
    chk("R5", "cfg byte lane 1", 32'(cap_be), 32'hD);
    access(1'b0, 32'h8000_3000, 2'd2, 32'h0);
    chk("R4", "cfg dev6 accepted", {30'd0, got_err, cap_req}, 32'h1);
    access(1'b0, 32'h8000_3800, 2'd2, 32'h0);
    chk("R4", "cfg dev7 refused", {30'd0, got_err, cap_req}, 32'h2);
    access(1'b0, 32'h8000_9800, 2'd2, 32'h0);
    chk("R4", "cfg dev19 refused", {30'd0, got_err, cap_req}, 32'h2);
    access(1'b0, 32'h8001_0000, 2'd2, 32'h0);
    chk("R4", "cfg high offset refused", got_rdata, 32'hFFFF_FFFF);

    // randomized traffic, compared against the model every cycle
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      if ($urandom % 6 == 0) reg_write($urandom);
      if ($urandom % 8 == 0) reg_read(v);
      resp_delay = $urandom % 4;
      resp_abort = ($urandom % 6 == 0);
      resp_data  = $urandom;
      a = $urandom;
      if ($urandom % 4 != 0) a[31:30] = 2'b10;
      if ($urandom % 2 == 0) a[29:16] = '0;
      access($urandom % 2 == 1, a, 2'($urandom), $urandom);
    end

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule